// File: doc/BRIEF.md
# On-screen display control core with blink timer

This block is the control core of an on-screen display overlay. It holds a small control register that software writes and reads back through a plain write/read port. The register carries four settings: a display run bit, a composite-video overlay enable, a blink period select and an interlace select. From these settings the block decodes the enables for the digital overlay output and the composite-video overlay output.

The block also produces a character blink phase with a 50% duty cycle by counting rising edges of a vertical sync pulse. The period is either a short or a long number of fields. In interlaced mode it tracks the field parity at each vertical sync. It arbitrates the character ROM: the CPU is granted the ROM only while the display is stopped, and the display engine owns it otherwise.

Top module: `osd_ctrl_core`

## Requirements
- R1: With the blink select bit (bit 2) at 0, the blink output toggles after every 16 counted vertical sync rising edges, so the full period is 32 fields at 50% duty.
- R2: With the blink select bit at 1, the blink output toggles after every 32 counted vertical sync rising edges, so the full period is 64 fields.
- R3: While the run bit (bit 0) is 0, the digital and composite enables are both 0 whatever the composite enable bit (bit 1) holds, and the blink output and its counter are held at 0.
- R4: With run at 1 and the composite enable bit at 0, only the digital enable is 1.
- R5: With run at 1 and the composite enable bit at 1, both the digital and composite enables are 1.
- R6: The ROM grant follows the ROM request in the same cycle while run is 0, and stays 0 while run is 1.
- R7: With the interlace bit (bit 3) at 1, the field output takes the field input sampled at each vertical sync rising edge. With the interlace bit at 0, the field output is 0.
- R8: After reset, all control bits read 0 and every output is 0.
- R9: A register write takes effect on the next clock edge and reads back at once. Bits above bit 3 read as 0. The output enables follow one clock later.
- R10: A change of the blink select bit restarts the blink counter and the blink phase at 0, so the first toggle comes a full half period after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Control register write strobe |
| wr_data_i | input | DATA_W | Control register write data |
| rd_data_o | output | DATA_W | Control register read data |
| vsync_i | input | 1 | Vertical sync pulse, synchronous to clk |
| field_i | input | 1 | Field parity input |
| rom_req_i | input | 1 | CPU request for character ROM |
| rom_gnt_o | output | 1 | CPU grant of character ROM |
| dig_en_o | output | 1 | Digital overlay output enable |
| cv_en_o | output | 1 | Composite-video overlay output enable |
| blink_o | output | 1 | Character blink phase |
| field_o | output | 1 | Tracked field parity |

## Verification
The bench builds the block with its default parameters: an 8-bit data port, a 16-edge half period for the short blink and a 32-edge half period for the long blink. These values keep a full long blink period within a few hundred clocks. The bench can therefore count every toggle edge exactly, including the first toggle after a period change that arrives in the middle of a half period.

// File: rtl/osd_ctrl_pkg.sv
package osd_ctrl_pkg;
  localparam int unsigned RUN_BIT  = 0;
  localparam int unsigned CV_BIT   = 1;
  localparam int unsigned LONG_BIT = 2;
  localparam int unsigned LACE_BIT = 3;

  typedef struct packed {
    logic lace;
    logic blink_long;
    logic cv_en;
    logic run;
  } osd_ctl_t;
endpackage

// File: rtl/osd_ctrl_regs.sv
module osd_ctrl_regs
  import osd_ctrl_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output osd_ctl_t          ctl_o,
  output logic [DATA_W-1:0] rd_data_o
);
  osd_ctl_t ctl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= '0;
    end else if (wr_en_i) begin
      ctl_q.run        <= wr_data_i[RUN_BIT];
      ctl_q.cv_en      <= wr_data_i[CV_BIT];
      ctl_q.blink_long <= wr_data_i[LONG_BIT];
      ctl_q.lace       <= wr_data_i[LACE_BIT];
    end
  end

  always_comb begin
    rd_data_o           = '0;
    rd_data_o[RUN_BIT]  = ctl_q.run;
    rd_data_o[CV_BIT]   = ctl_q.cv_en;
    rd_data_o[LONG_BIT] = ctl_q.blink_long;
    rd_data_o[LACE_BIT] = ctl_q.lace;
  end

  assign ctl_o = ctl_q;
endmodule

// File: rtl/osd_vsync_edge.sv
module osd_vsync_edge (
  input  logic clk,
  input  logic rst,
  input  logic vsync_i,
  output logic rise_o
);
  logic vs_q;

  always_ff @(posedge clk) begin
    if (rst) vs_q <= 1'b0;
    else     vs_q <= vsync_i;
  end

  assign rise_o = vsync_i & ~vs_q;
endmodule

// File: rtl/osd_blink_timer.sv
module osd_blink_timer #(
  parameter int unsigned HALF_SHORT = 16,
  parameter int unsigned HALF_LONG  = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  input  logic long_sel_i,
  input  logic vs_rise_i,
  output logic blink_o
);
  localparam int unsigned HALF_MAX = (HALF_LONG > HALF_SHORT) ? HALF_LONG : HALF_SHORT;
  localparam int unsigned CNT_W    = (HALF_MAX > 2) ? $clog2(HALF_MAX) : 1;
  localparam logic [CNT_W-1:0] LAST_S = CNT_W'(HALF_SHORT - 1);
  localparam logic [CNT_W-1:0] LAST_L = CNT_W'(HALF_LONG - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             phase_q;
  logic             sel_q;
  logic [CNT_W-1:0] last;

  assign last = long_sel_i ? LAST_L : LAST_S;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
      sel_q   <= 1'b0;
    end else begin
      sel_q <= long_sel_i;
      if (!run_i || (sel_q != long_sel_i)) begin
        cnt_q   <= '0;
        phase_q <= 1'b0;
      end else if (vs_rise_i) begin
        if (cnt_q == last) begin
          cnt_q   <= '0;
          phase_q <= ~phase_q;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign blink_o = phase_q;
endmodule

// File: rtl/osd_out_gate.sv
module osd_out_gate
  import osd_ctrl_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  osd_ctl_t ctl_i,
  input  logic     vs_rise_i,
  input  logic     field_i,
  input  logic     rom_req_i,
  output logic     rom_gnt_o,
  output logic     dig_en_o,
  output logic     cv_en_o,
  output logic     field_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      dig_en_o <= 1'b0;
      cv_en_o  <= 1'b0;
      field_o  <= 1'b0;
    end else begin
      dig_en_o <= ctl_i.run;
      cv_en_o  <= ctl_i.run & ctl_i.cv_en;
      if (!ctl_i.lace)    field_o <= 1'b0;
      else if (vs_rise_i) field_o <= field_i;
    end
  end

  assign rom_gnt_o = rom_req_i & ~ctl_i.run;
endmodule

// File: rtl/osd_ctrl_core.sv
module osd_ctrl_core
  import osd_ctrl_pkg::*;
#(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned HALF_SHORT = 16,
  parameter int unsigned HALF_LONG  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              vsync_i,
  input  logic              field_i,
  input  logic              rom_req_i,
  output logic              rom_gnt_o,
  output logic              dig_en_o,
  output logic              cv_en_o,
  output logic              blink_o,
  output logic              field_o
);
  osd_ctl_t ctl;
  logic     vs_rise;

  osd_ctrl_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .ctl_o(ctl), .rd_data_o(rd_data_o)
  );

  osd_vsync_edge u_edge (
    .clk(clk), .rst(rst), .vsync_i(vsync_i), .rise_o(vs_rise)
  );

  osd_blink_timer #(.HALF_SHORT(HALF_SHORT), .HALF_LONG(HALF_LONG)) u_blink (
    .clk(clk), .rst(rst), .run_i(ctl.run), .long_sel_i(ctl.blink_long),
    .vs_rise_i(vs_rise), .blink_o(blink_o)
  );

  osd_out_gate u_gate (
    .clk(clk), .rst(rst), .ctl_i(ctl), .vs_rise_i(vs_rise), .field_i(field_i),
    .rom_req_i(rom_req_i), .rom_gnt_o(rom_gnt_o), .dig_en_o(dig_en_o),
    .cv_en_o(cv_en_o), .field_o(field_o)
  );
endmodule

// File: rtl/osd_ctrl_core_chk.sv
module osd_ctrl_core_chk
  import osd_ctrl_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              rom_req_i,
  input logic              rom_gnt_o,
  input logic              dig_en_o,
  input logic              cv_en_o,
  input logic              blink_o,
  input logic              field_o
);
  assert_stop_outputs_off_R3: assert property (@(posedge clk) disable iff (rst)
    !rd_data_o[RUN_BIT] |=> (!dig_en_o && !cv_en_o));

  assert_stop_blink_low_R3: assert property (@(posedge clk) disable iff (rst)
    !rd_data_o[RUN_BIT] |=> !blink_o);

  assert_cv_needs_dig_R5: assert property (@(posedge clk) disable iff (rst)
    cv_en_o |-> dig_en_o);

  assert_gnt_only_stopped_R6: assert property (@(posedge clk) disable iff (rst)
    rom_gnt_o |-> (rom_req_i && !rd_data_o[RUN_BIT]));

  assert_field_low_progressive_R7: assert property (@(posedge clk) disable iff (rst)
    !rd_data_o[LACE_BIT] |=> !field_o);

  assert_dig_follows_run_R9: assert property (@(posedge clk) disable iff (rst)
    rd_data_o[RUN_BIT] |=> dig_en_o);
endmodule

bind osd_ctrl_core osd_ctrl_core_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .rd_data_o(rd_data_o), .rom_req_i(rom_req_i),
  .rom_gnt_o(rom_gnt_o), .dig_en_o(dig_en_o), .cv_en_o(cv_en_o),
  .blink_o(blink_o), .field_o(field_o)
);

// File: tb/osd_ctrl_core_test.sv
`timescale 1ns/1ps
module osd_ctrl_core_test;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en_i = 1'b0;
  logic [DW-1:0] wr_data_i = '0;
  logic [DW-1:0] rd_data_o;
  logic          vsync_i = 1'b0;
  logic          field_i = 1'b0;
  logic          rom_req_i = 1'b0;
  logic          rom_gnt_o, dig_en_o, cv_en_o, blink_o, field_o;

  int total = 0;
  int bad   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  osd_ctrl_core uut (
    .clk(clk), .rst(rst), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .rd_data_o(rd_data_o), .vsync_i(vsync_i), .field_i(field_i),
    .rom_req_i(rom_req_i), .rom_gnt_o(rom_gnt_o), .dig_en_o(dig_en_o),
    .cv_en_o(cv_en_o), .blink_o(blink_o), .field_o(field_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // control value: bit0 run, bit1 composite, bit2 long blink, bit3 interlace
  task automatic wr(input logic [DW-1:0] v);
    wr_en_i = 1'b1; wr_data_i = v;
    @(negedge clk);
    wr_en_i = 1'b0; wr_data_i = '0;
    @(negedge clk);
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      vsync_i = 1'b1;
      @(negedge clk);
      vsync_i = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic t_reset_R8();
    chk("R8 rd_data", int'(rd_data_o), 0);
    chk("R8 dig_en", dig_en_o, 0);
    chk("R8 cv_en", cv_en_o, 0);
    chk("R8 blink", blink_o, 0);
    chk("R8 field", field_o, 0);
  endtask

  task automatic t_enables();
    wr_en_i = 1'b1; wr_data_i = 8'hF2;
    @(negedge clk);
    wr_en_i = 1'b0;
    chk("R9 readback next clock", int'(rd_data_o), 2);
    chk("R9 enable lags one clock", cv_en_o, 0);
    @(negedge clk);
    chk("R3 dig off while stopped", dig_en_o, 0);
    chk("R3 cv off while stopped", cv_en_o, 0);
    pulses(20);
    chk("R3 blink held while stopped", blink_o, 0);
    wr(8'h01);
    chk("R4 dig on", dig_en_o, 1);
    chk("R4 cv off", cv_en_o, 0);
    wr(8'h03);
    chk("R5 dig on", dig_en_o, 1);
    chk("R5 cv on", cv_en_o, 1);
  endtask

  task automatic t_rom_R6();
    wr(8'h00);
    rom_req_i = 1'b1; #1;
    chk("R6 grant when stopped", rom_gnt_o, 1);
    rom_req_i = 1'b0; #1;
    chk("R6 no grant without request", rom_gnt_o, 0);
    wr(8'h01);
    rom_req_i = 1'b1; #1;
    chk("R6 no grant while running", rom_gnt_o, 0);
    rom_req_i = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_blink_short();
    wr(8'h00);
    wr(8'h01);
    pulses(15);
    chk("R1 before 16th edge", blink_o, 0);
    pulses(1);
    chk("R1 toggle at 16th edge", blink_o, 1);
    pulses(15);
    chk("R1 high for half period", blink_o, 1);
    pulses(1);
    chk("R1 back low at 32nd edge", blink_o, 0);
  endtask

  task automatic t_blink_long();
    wr(8'h00);
    wr(8'h01);
    pulses(20);
    chk("R10 short phase before change", blink_o, 1);
    wr(8'h05);
    chk("R10 phase restarts on select change", blink_o, 0);
    pulses(31);
    chk("R2 before 32nd edge", blink_o, 0);
    pulses(1);
    chk("R2 toggle at 32nd edge", blink_o, 1);
    pulses(32);
    chk("R2 low after second half", blink_o, 0);
    wr(8'h00);
    chk("R3 blink cleared on stop", blink_o, 0);
  endtask

  task automatic t_field_R7();
    wr(8'h08);
    field_i = 1'b1;
    pulses(1);
    chk("R7 field captured at vsync", field_o, 1);
    field_i = 1'b0;
    repeat (3) @(negedge clk);
    chk("R7 field holds between vsyncs", field_o, 1);
    pulses(1);
    chk("R7 field low captured", field_o, 0);
    field_i = 1'b1;
    pulses(1);
    wr(8'h00);
    chk("R7 field forced low in progressive", field_o, 0);
    pulses(1);
    chk("R7 field ignores vsync in progressive", field_o, 0);
    field_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset_R8();
    t_enables();
    t_rom_R6();
    t_blink_short();
    t_blink_long();
    t_field_R7();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule